// File: doc/BRIEF.md
# Dataflow Wakeup and Issue Scheduler

This block tracks readiness for a 32-slot window of decoded instructions. It issues one instruction per cycle in dataflow order. Each slot keeps two groups of ready state. The first group is loaded once by the front-end decoder and never changes after that. The second group is the live state that the back end accumulates as results arrive. Every slot is re-evaluated on every clock. A slot becomes ready when all four of its inputs are satisfied: predicate-true, predicate-false, left operand and right operand. It must also not have issued already.

The back end sends wakeups in three ways: two explicit target events, each naming one slot and one input side; an optional broadcast channel number that matches every slot listening on that channel; and four per-input enables that say which ready bit an event actually sets. The lowest-numbered ready slot is issued, and its index is presented as a binary number. That slot is then blocked from issuing again. Wakeups sent during the issue cycle count towards the next cycle's choice, so a chain of dependent instructions can issue on consecutive cycles.

A block-reset pulse discards the whole window. A block-refresh pulse keeps the decoded state and clears only the live state, so a loop can be replayed without decoding it again.

Top module: `dflow_sched`

## Requirements
- R1: After chip reset (rst_n low) or a block-reset pulse, issueValid is 0 and issueIdx is 0 until some slot becomes ready.
- R2: A slot decoded with all four input bits set becomes visible on issueValid/issueIdx after the second rising edge following its decode write. The decode is written on the first edge and the live state on the second.
- R3: When several slots are ready, issueIdx carries the lowest-numbered ready slot as a 5-bit binary index. Exactly one slot issues per cycle while any slot is ready.
- R4: A slot that has issued never issues again until a block reset or block refresh.
- R5: A target event is {side, index[4:0]}. Side 0 addresses predicate-false or operand 0, and side 1 addresses predicate-true or operand 1. Enables enRt, enRf, enR0 and enR1 choose the bit that is set. Both target ports act in the same cycle, and an event given in the issue cycle lets the target issue in the next cycle.
- R6: A nonzero evtBid sets the enabled input bits in every decoded slot with the same channel. evtBid = 0, or a channel that differs from the slot's, has no effect.
- R7: A slot predicated on true is decoded with only the false-ready bit set. It issues only after a predicate-true event, and a predicate-false event does not wake it.
- R8: Events aimed at a slot that has not yet been decoded are kept, and they count once the slot is decoded.
- R9: Block refresh clears the live state, including the issued mark, and keeps the decoded state. A fully decoded slot therefore issues again one edge after the refresh edge.
- R10: Block reset clears decoded and live state, and it overrides any events in the same cycle.
- R11: Block refresh overrides any events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| blockReset | input | 1 | Discard the window: clear decoded and live state |
| blockRefresh | input | 1 | Replay the window: clear live state only |
| decWrEn | input | 1 | Decoder write strobe |
| decWrIdx | input | 5 | Slot being decoded |
| decBid | input | 2 | Broadcast channel of the slot, 0 for none |
| decRt | input | 1 | Decoded predicate-true ready |
| decRf | input | 1 | Decoded predicate-false ready |
| decR0 | input | 1 | Decoded operand-0 ready |
| decR1 | input | 1 | Decoded operand-1 ready |
| tgt0Valid | input | 1 | Target event 0 present |
| tgt0 | input | 6 | Target event 0: {side, index} |
| tgt1Valid | input | 1 | Target event 1 present |
| tgt1 | input | 6 | Target event 1: {side, index} |
| evtBid | input | 2 | Broadcast channel of this cycle's result, 0 for none |
| enRt | input | 1 | Events set predicate-true ready |
| enRf | input | 1 | Events set predicate-false ready |
| enR0 | input | 1 | Events set operand-0 ready |
| enR1 | input | 1 | Events set operand-1 ready |
| issueValid | output | 1 | A slot is issuing this cycle |
| issueIdx | output | 5 | Index of the issuing slot |

## Verification
Any corrupted ready bit shows up at issueIdx no later than the edge that follows the wakeup, because the issue outputs come straight from the registered ready vector. A lost wakeup leaves a slot silent. A lost issued mark makes the same index appear twice in a row. A wrong priority puts an index out of ascending order during the full-window broadcast sweep. When refresh or reset fails to clear the right state, the result is visible within one or two cycles of the pulse: a slot issues when it should not, or a replayed slot stays silent.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int SCHED_ENTRIES = 32;
  localparam int SCHED_BID_W   = 2;

  typedef struct packed {
    logic rt;
    logic rf;
    logic r0;
    logic r1;
  } inBits_t;

  typedef struct packed {
    logic [SCHED_BID_W-1:0] bid;
    inBits_t                bits;
  } decState_t;

  typedef struct packed {
    logic clrDec;
    logic clrAct;
  } ctrlStrobe_t;
endpackage

// File: rtl/sched_prienc.sv
module sched_prienc #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     reqVec,
  output logic             anyReq,
  output logic [IDX_W-1:0] firstIdx
);
  always_comb begin
    firstIdx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (reqVec[k]) firstIdx = IDX_W'(k);
    end
  end
  assign anyReq = |reqVec;
endmodule

// File: rtl/sched_entry.sv
module sched_entry
  import sched_pkg::*;
#(
  parameter int BID_W = SCHED_BID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic             decLoad,
  input  decState_t        decIn,
  input  logic             hitSide0,
  input  logic             hitSide1,
  input  logic [BID_W-1:0] evtBid,
  input  inBits_t          evtEn,
  input  logic             issueHit,
  output logic             rdy
);
  decState_t decQ;
  inBits_t   actQ, actNext;
  logic      inhQ, inhNext, rdyNext, bcastHit;

  assign bcastHit = (evtBid != '0) && (evtBid == decQ.bid);

  always_comb begin
    actNext.rt = actQ.rt | decQ.bits.rt | (evtEn.rt & (hitSide1 | bcastHit));
    actNext.rf = actQ.rf | decQ.bits.rf | (evtEn.rf & (hitSide0 | bcastHit));
    actNext.r0 = actQ.r0 | decQ.bits.r0 | (evtEn.r0 & (hitSide0 | bcastHit));
    actNext.r1 = actQ.r1 | decQ.bits.r1 | (evtEn.r1 & (hitSide1 | bcastHit));
    inhNext    = inhQ | issueHit;
    rdyNext    = actNext.rt & actNext.rf & actNext.r0 & actNext.r1 & ~inhNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decQ <= '0;
    end else if (strobe.clrDec) begin
      decQ <= '0;
    end else if (decLoad) begin
      decQ <= decIn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actQ <= '0;
      inhQ <= 1'b0;
      rdy  <= 1'b0;
    end else if (strobe.clrAct) begin
      actQ <= '0;
      inhQ <= 1'b0;
      rdy  <= 1'b0;
    end else begin
      actQ <= actNext;
      inhQ <= inhNext;
      rdy  <= rdyNext;
    end
  end
endmodule

// File: rtl/sched_datapath.sv
module sched_datapath
  import sched_pkg::*;
#(
  parameter int N     = SCHED_ENTRIES,
  parameter int BID_W = SCHED_BID_W,
  localparam int IDX_W = $clog2(N),
  localparam int EVT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic             decWrEn,
  input  logic [IDX_W-1:0] decWrIdx,
  input  decState_t        decIn,
  input  logic             tgt0Valid,
  input  logic [EVT_W-1:0] tgt0,
  input  logic             tgt1Valid,
  input  logic [EVT_W-1:0] tgt1,
  input  logic [BID_W-1:0] evtBid,
  input  inBits_t          evtEn,
  input  logic             issueValid,
  input  logic [IDX_W-1:0] issueIdx,
  output logic [N-1:0]     rdyVec
);
  for (genvar i = 0; i < N; i++) begin : gEntry
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    logic hitSide0, hitSide1, decLoad, issueHit;

    assign hitSide0 = (tgt0Valid && tgt0 == {1'b0, SLOT})
                    | (tgt1Valid && tgt1 == {1'b0, SLOT});
    assign hitSide1 = (tgt0Valid && tgt0 == {1'b1, SLOT})
                    | (tgt1Valid && tgt1 == {1'b1, SLOT});
    assign decLoad  = decWrEn && (decWrIdx == SLOT);
    assign issueHit = issueValid && (issueIdx == SLOT);

    sched_entry #(.BID_W(BID_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .decLoad  (decLoad),
      .decIn    (decIn),
      .hitSide0 (hitSide0),
      .hitSide1 (hitSide1),
      .evtBid   (evtBid),
      .evtEn    (evtEn),
      .issueHit (issueHit),
      .rdy      (rdyVec[i])
    );
  end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int N = SCHED_ENTRIES,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             blockReset,
  input  logic             blockRefresh,
  input  logic [N-1:0]     rdyVec,
  output ctrlStrobe_t      strobe,
  output logic             issueValid,
  output logic [IDX_W-1:0] issueIdx
);
  always_comb begin
    strobe.clrDec = blockReset;
    strobe.clrAct = blockReset | blockRefresh;
  end

  sched_prienc #(.N(N), .IDX_W(IDX_W)) u_pick (
    .reqVec   (rdyVec),
    .anyReq   (issueValid),
    .firstIdx (issueIdx)
  );
endmodule

// File: rtl/dflow_sched.sv
module dflow_sched
  import sched_pkg::*;
#(
  parameter int N     = SCHED_ENTRIES,
  parameter int BID_W = SCHED_BID_W,
  localparam int IDX_W = $clog2(N),
  localparam int EVT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blockReset,
  input  logic             blockRefresh,
  input  logic             decWrEn,
  input  logic [IDX_W-1:0] decWrIdx,
  input  logic [BID_W-1:0] decBid,
  input  logic             decRt,
  input  logic             decRf,
  input  logic             decR0,
  input  logic             decR1,
  input  logic             tgt0Valid,
  input  logic [EVT_W-1:0] tgt0,
  input  logic             tgt1Valid,
  input  logic [EVT_W-1:0] tgt1,
  input  logic [BID_W-1:0] evtBid,
  input  logic             enRt,
  input  logic             enRf,
  input  logic             enR0,
  input  logic             enR1,
  output logic             issueValid,
  output logic [IDX_W-1:0] issueIdx
);
  ctrlStrobe_t strobe;
  decState_t   decIn;
  inBits_t     evtEn;
  logic [N-1:0] rdyVec;

  assign decIn = '{bid: decBid, bits: '{rt: decRt, rf: decRf, r0: decR0, r1: decR1}};
  assign evtEn = '{rt: enRt, rf: enRf, r0: enR0, r1: enR1};

  sched_ctrl #(.N(N)) u_ctrl (
    .blockReset   (blockReset),
    .blockRefresh (blockRefresh),
    .rdyVec       (rdyVec),
    .strobe       (strobe),
    .issueValid   (issueValid),
    .issueIdx     (issueIdx)
  );

  sched_datapath #(.N(N), .BID_W(BID_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .decWrEn    (decWrEn),
    .decWrIdx   (decWrIdx),
    .decIn      (decIn),
    .tgt0Valid  (tgt0Valid),
    .tgt0       (tgt0),
    .tgt1Valid  (tgt1Valid),
    .tgt1       (tgt1),
    .evtBid     (evtBid),
    .evtEn      (evtEn),
    .issueValid (issueValid),
    .issueIdx   (issueIdx),
    .rdyVec     (rdyVec)
  );
endmodule

// File: rtl/dflow_sched_chk.sv
module dflow_sched_chk #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blockReset,
  input logic             blockRefresh,
  input logic             issueValid,
  input logic [IDX_W-1:0] issueIdx,
  input logic [N-1:0]     rdyVec
);
  logic [N-1:0] belowMask;
  assign belowMask = (N'(1) << issueIdx) - N'(1);

  AST_RESET_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blockReset) |-> !issueValid); // R1

  AST_REFRESH_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blockRefresh) |-> !issueValid); // R9

  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issueValid) |-> !(issueValid && issueIdx == $past(issueIdx))); // R4

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> (rdyVec[issueIdx] && ((rdyVec & belowMask) == '0))); // R3

  AST_ISSUE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rdyVec != '0) |-> issueValid); // R3
endmodule

bind dflow_sched dflow_sched_chk #(.N(N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .blockReset   (blockReset),
  .blockRefresh (blockRefresh),
  .issueValid   (issueValid),
  .issueIdx     (issueIdx),
  .rdyVec       (rdyVec)
);

// File: tb/dflow_sched_bench.sv
module dflow_sched_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blockReset = 1'b0, blockRefresh = 1'b0;
  logic decWrEn = 1'b0;
  logic [4:0] decWrIdx = '0;
  logic [1:0] decBid = '0;
  logic decRt = 1'b0, decRf = 1'b0, decR0 = 1'b0, decR1 = 1'b0;
  logic tgt0Valid = 1'b0, tgt1Valid = 1'b0;
  logic [5:0] tgt0 = '0, tgt1 = '0;
  logic [1:0] evtBid = '0;
  logic enRt = 1'b0, enRf = 1'b0, enR0 = 1'b0, enR1 = 1'b0;
  logic issueValid;
  logic [4:0] issueIdx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dflow_sched u_dflow_sched (
    .clk(clk), .rst_n(rst_n), .blockReset(blockReset), .blockRefresh(blockRefresh),
    .decWrEn(decWrEn), .decWrIdx(decWrIdx), .decBid(decBid),
    .decRt(decRt), .decRf(decRf), .decR0(decR0), .decR1(decR1),
    .tgt0Valid(tgt0Valid), .tgt0(tgt0), .tgt1Valid(tgt1Valid), .tgt1(tgt1),
    .evtBid(evtBid), .enRt(enRt), .enRf(enRf), .enR0(enR0), .enR1(enR1),
    .issueValid(issueValid), .issueIdx(issueIdx)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic expValid, logic [4:0] expIdx);
    checks++;
    if (issueValid !== expValid || (expValid && issueIdx !== expIdx)) begin
      fails++;
      $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
               req, issueValid, issueIdx, expValid, expIdx);
    end
  endtask

  task automatic decWrite(logic [4:0] idx, logic [1:0] bid,
                          logic rt, logic rf, logic r0, logic r1);
    decWrEn = 1'b1; decWrIdx = idx; decBid = bid;
    decRt = rt; decRf = rf; decR0 = r0; decR1 = r1;
    tick();
    decWrEn = 1'b0;
  endtask

  task automatic clearEvents();
    tgt0Valid = 1'b0; tgt1Valid = 1'b0; evtBid = '0;
    enRt = 1'b0; enRf = 1'b0; enR0 = 1'b0; enR1 = 1'b0;
  endtask

  task automatic pulseBlockReset();
    blockReset = 1'b1;
    tick();
    blockReset = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 chip reset", 1'b0, 5'd0);
    checks++;
    if (issueIdx !== 5'd0) begin
      fails++;
      $display("FAIL R1 idle index: got %0d, expected 0", issueIdx);
    end
    rst_n = 1'b1;
    tick();
    chk("R1 after reset release", 1'b0, 5'd0);

    // Full-window sweep: every slot waits on operand 0 through channel 1
    for (int i = 0; i < 32; i++) decWrite(5'(i), 2'd1, 1'b1, 1'b1, 1'b0, 1'b1);
    evtBid = 2'd2; enR0 = 1'b1;
    tick();
    clearEvents();
    chk("R6 other channel", 1'b0, 5'd0);
    evtBid = 2'd0; enR0 = 1'b1;
    tick();
    clearEvents();
    chk("R6 channel zero", 1'b0, 5'd0);
    evtBid = 2'd1; enR0 = 1'b1;
    tick();
    clearEvents();
    for (int k = 0; k < 32; k++) begin
      chk("R3 ascending order", 1'b1, 5'(k));
      tick();
    end
    chk("R4 no reissue after sweep", 1'b0, 5'd0);
    tick();
    chk("R4 still idle", 1'b0, 5'd0);

    // Dependent chain with both target ports
    pulseBlockReset();
    chk("R1 block reset", 1'b0, 5'd0);
    decWrite(5'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
    decWrite(5'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    decWrite(5'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R2 not before second edge", 1'b0, 5'd0);
    tick();
    chk("R2 zero-input slot", 1'b1, 5'd0);
    tgt0Valid = 1'b1; tgt0 = {1'b0, 5'd1};
    tgt1Valid = 1'b1; tgt1 = {1'b1, 5'd2};
    enR0 = 1'b1; enR1 = 1'b1;
    tick();
    clearEvents();
    chk("R5 back-to-back wakeup", 1'b1, 5'd1);
    tick();
    chk("R5 second target", 1'b1, 5'd2);
    tick();
    chk("R4 chain drained", 1'b0, 5'd0);

    // Refresh keeps decoded state
    blockRefresh = 1'b1;
    tick();
    blockRefresh = 1'b0;
    chk("R9 refresh clears", 1'b0, 5'd0);
    tick();
    chk("R9 replay slot 0", 1'b1, 5'd0);
    tick();
    chk("R9 waiting slots stay idle", 1'b0, 5'd0);

    // Predication on true
    pulseBlockReset();
    decWrite(5'd3, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    tick();
    chk("R7 waits for predicate", 1'b0, 5'd0);
    tgt0Valid = 1'b1; tgt0 = {1'b0, 5'd3}; enRf = 1'b1;
    tick();
    clearEvents();
    tick();
    chk("R7 false predicate ignored", 1'b0, 5'd0);
    tgt0Valid = 1'b1; tgt0 = {1'b1, 5'd3}; enRt = 1'b1;
    tick();
    clearEvents();
    chk("R7 true predicate wakes", 1'b1, 5'd3);
    tick();

    // Event before decode
    pulseBlockReset();
    tgt1Valid = 1'b1; tgt1 = {1'b0, 5'd7}; enR0 = 1'b1;
    tick();
    clearEvents();
    chk("R8 undecoded stays idle", 1'b0, 5'd0);
    decWrite(5'd7, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
    tick();
    chk("R8 early event honoured", 1'b1, 5'd7);
    tick();

    // Reset beats same-cycle event
    pulseBlockReset();
    decWrite(5'd4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
    blockReset = 1'b1; tgt0Valid = 1'b1; tgt0 = {1'b0, 5'd4}; enR0 = 1'b1;
    tick();
    blockReset = 1'b0;
    tick();
    clearEvents();
    chk("R10 decoded state gone", 1'b0, 5'd0);
    tick();
    chk("R10 still idle", 1'b0, 5'd0);

    // Refresh beats same-cycle event
    pulseBlockReset();
    decWrite(5'd5, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
    blockRefresh = 1'b1; tgt0Valid = 1'b1; tgt0 = {1'b0, 5'd5}; enR0 = 1'b1;
    tick();
    blockRefresh = 1'b0;
    clearEvents();
    tick();
    chk("R11 event dropped", 1'b0, 5'd0);
    tgt0Valid = 1'b1; tgt0 = {1'b0, 5'd5}; enR0 = 1'b1;
    tick();
    clearEvents();
    chk("R11 later event wakes", 1'b1, 5'd5);

    done = 1'b1;
    summary();
  end
endmodule